// File: doc/BRIEF.md
# Nearest-Neighbour Access Sequencer with Machine Stall

This block sits between the address generator of one node and the rest of a three-dimensional torus of nodes. Each request carries a data address. The top three bits of that address are a route code that can be computed at run time. The remaining bits are the memory word address, which is the same on every node. A route code of zero is a plain local access. It goes straight to the node's own memory and completes in one cycle.

A route code naming one of the six neighbours turns the request into a link transfer. The transfer uses one axis pair only. The data word is cut into equal chunks and sent over that link in consecutive time slots, least significant chunk first. For a remote read, the chunks returned by the link are gathered back into a word. A remote access therefore lasts four slot cycles with the default parameters, four times a local one. For that whole window the block raises a stall that the rest of the machine uses to freeze the compute unit, memory and controller. All nodes step in the same direction together, so the link never sees contention, and a move over distance n is issued as n separate unit steps.

Top module: `nn_access_seq`

## Requirements
- R1: The route code is `req_addr[ADDR_W-1:ADDR_W-3]` and the word address is `req_addr[ADDR_W-4:0]`. A request with route code 0, accepted at a clock edge, drives `mem_en`=1 and `mem_addr` equal to the word address in the following cycle. `mem_we` and `mem_wdata` copy the request's write flag and data in that cycle.
- R2: A local access raises `done` in that same single cycle and leaves `stall` low. For a local read, `rd_data` equals `mem_rdata` in that cycle. Whenever `done` is low or the access is a write, `rd_data` is 0.
- R3: Route codes 1–6 name the neighbours in this order: X−, X+, Y−, Y+, Z−, Z+. During a remote access, `link_axis` gives the axis pair (1=X, 2=Y, 3=Z) and `link_pos` is 1 for the positive direction. Both are 0 when no link transfer is running.
- R4: A remote access holds `link_en` and `stall` high for exactly SLOTS consecutive cycles, starting in the cycle after acceptance. `link_slot` counts 0 to SLOTS−1 during those cycles, and `mem_addr` holds the word address. `mem_en` stays low.
- R5: `done` rises in the final slot cycle of a remote access, and `stall` is low in the next cycle.
- R6: For a remote write, `link_we`=1 and `link_tx` in slot s carries bits [s·CHUNK_W +: CHUNK_W] of the write data. For a remote read, `link_tx` is 0.
- R7: For a remote read, `rd_data` in the `done` cycle is the word whose chunk s is the `link_rx` value presented in slot s.
- R8: A request presented while `stall` is high is ignored. It produces no access, no error and no output change, either during the stall or after it.
- R9: Route code 7 is reserved. Accepting it raises `err` for one cycle and starts no memory access, no link transfer, no stall and no `done`.
- R10: While reset is asserted, every output of the block is 0.
- R11: `mem_en` and `link_en` are never high together, and `err` never coincides with `done`.
- R12: Local requests can be accepted on consecutive cycles, one access per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_we | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Route code (top 3 bits) and word address |
| req_wdata | input | DATA_W | Write data |
| mem_en | output | 1 | Local memory access strobe |
| mem_we | output | 1 | Local memory write |
| mem_addr | output | ADDR_W-3 | Word address for the current access |
| mem_wdata | output | DATA_W | Local write data |
| mem_rdata | input | DATA_W | Local memory read data, same cycle |
| link_en | output | 1 | Link transfer slot active |
| link_axis | output | 2 | Active axis pair: 1 X, 2 Y, 3 Z |
| link_pos | output | 1 | Positive direction on that axis |
| link_slot | output | $clog2(SLOTS) | Time-slot index of the current chunk |
| link_we | output | 1 | Link transfer is a write |
| link_tx | output | DATA_W/SLOTS | Outgoing chunk |
| link_rx | input | DATA_W/SLOTS | Incoming chunk for the current slot |
| stall | output | 1 | Machine-wide freeze during a remote access |
| done | output | 1 | Data-valid / completion strobe |
| rd_data | output | DATA_W | Read result, valid with `done` |
| err | output | 1 | Reserved route code was accepted |

## Verification
The assertions assume that `req_valid` and `req_addr` are known values at every active edge after reset. They also assume that `link_rx` and `mem_rdata` are settled by the end of the cycle in which they are used. The bench drives requests only at the falling edge, so every input is stable across the rising edge that samples it.

The bench derives `mem_rdata` from `mem_addr` through a fixed function. It derives `link_rx` from `mem_addr`, `link_axis` and `link_slot`, so returned chunks stay consistent for the whole window of a transfer. Random traffic deliberately keeps presenting requests while the stall is high, so the ignore rule is exercised under load.

// File: rtl/nn_seq_pkg.sv
package nn_seq_pkg;

   localparam int ROUTE_W = 3;

   localparam logic [ROUTE_W-1:0] ROUTE_LOCAL = 3'd0;
   localparam logic [ROUTE_W-1:0] ROUTE_RSVD  = 3'd7;

   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_LOCAL  = 2'd1,
      ACC_REMOTE = 2'd2,
      ACC_BAD    = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      AX_NONE = 2'd0,
      AX_X    = 2'd1,
      AX_Y    = 2'd2,
      AX_Z    = 2'd3
   } axis_e;

   typedef struct packed {
      acc_kind_e kind;
      axis_e     axis;
      logic      pos;
   } route_t;

endpackage

// File: rtl/nn_route_decode.sv
module nn_route_decode
   import nn_seq_pkg::*;
(
   input  logic [ROUTE_W-1:0] code,
   output route_t             route
);

   always_comb begin
      route = '{kind: ACC_REMOTE, axis: AX_NONE, pos: 1'b0};
      unique case (code)
         3'd0: route.kind = ACC_LOCAL;
         3'd1: route.axis = AX_X;
         3'd2: begin route.axis = AX_X; route.pos = 1'b1; end
         3'd3: route.axis = AX_Y;
         3'd4: begin route.axis = AX_Y; route.pos = 1'b1; end
         3'd5: route.axis = AX_Z;
         3'd6: begin route.axis = AX_Z; route.pos = 1'b1; end
         default: route.kind = ACC_BAD;
      endcase
   end

endmodule

// File: rtl/nn_slot_seq.sv
module nn_slot_seq
   import nn_seq_pkg::*;
#(
   parameter  int SLOTS  = 4,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  route_t            in_route,
   output acc_kind_e         kind,
   output axis_e             axis,
   output logic              pos,
   output logic [SLOT_W-1:0] slot,
   output logic              last
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   assign last = (slot == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind <= ACC_NONE;
         axis <= AX_NONE;
         pos  <= 1'b0;
         slot <= '0;
      end else if (accept) begin
         kind <= in_route.kind;
         axis <= (in_route.kind == ACC_REMOTE) ? in_route.axis : AX_NONE;
         pos  <= (in_route.kind == ACC_REMOTE) && in_route.pos;
         slot <= '0;
      end else if (kind == ACC_REMOTE && !last) begin
         slot <= slot + 1'b1;
      end else begin
         kind <= ACC_NONE;
         axis <= AX_NONE;
         pos  <= 1'b0;
         slot <= '0;
      end
   end

endmodule

// File: rtl/nn_lane_mux.sv
module nn_lane_mux #(
   parameter  int DATA_W  = 32,
   parameter  int SLOTS   = 4,
   localparam int CHUNK_W = DATA_W / SLOTS,
   localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [SLOT_W-1:0]  slot,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [CHUNK_W-1:0] rx,
   output logic [CHUNK_W-1:0] tx,
   output logic [DATA_W-1:0]  word
);

   logic [CHUNK_W-1:0] lane [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_lane
      assign lane[g] = wdata[g*CHUNK_W +: CHUNK_W];
   end

   assign tx = lane[slot];

   for (genvar g = 0; g < SLOTS - 1; g++) begin : g_cap
      logic [CHUNK_W-1:0] held;
      always_ff @(posedge clk) begin
         if (!rst_n)
            held <= '0;
         else if (active && slot == SLOT_W'(g))
            held <= rx;
      end
      assign word[g*CHUNK_W +: CHUNK_W] = held;
   end

   assign word[DATA_W-1 -: CHUNK_W] = rx;

endmodule

// File: rtl/nn_access_seq.sv
module nn_access_seq
   import nn_seq_pkg::*;
#(
   parameter  int ADDR_W  = 16,
   parameter  int DATA_W  = 32,
   parameter  int SLOTS   = 4,
   localparam int MEM_AW  = ADDR_W - ROUTE_W,
   localparam int CHUNK_W = DATA_W / SLOTS,
   localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_we,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               mem_en,
   output logic               mem_we,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               link_en,
   output logic [1:0]         link_axis,
   output logic               link_pos,
   output logic [SLOT_W-1:0]  link_slot,
   output logic               link_we,
   output logic [CHUNK_W-1:0] link_tx,
   input  logic [CHUNK_W-1:0] link_rx,
   output logic               stall,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data,
   output logic               err
);

   if (ADDR_W <= ROUTE_W) begin : g_bad_addr
      $error("ADDR_W must leave room for a word address above the route code");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (DATA_W % SLOTS != 0) begin : g_bad_split
      $error("DATA_W must split evenly into SLOTS chunks");
   end

   route_t             req_route;
   acc_kind_e          kind;
   axis_e              axis;
   logic               pos;
   logic [SLOT_W-1:0]  slot;
   logic               last;
   logic               accept;
   logic               is_loc;
   logic               is_rem;
   logic [MEM_AW-1:0]  addr_q;
   logic               we_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [CHUNK_W-1:0] tx_chunk;
   logic [DATA_W-1:0]  rx_word;

   nn_route_decode u_dec (
      .code  (req_addr[ADDR_W-1 -: ROUTE_W]),
      .route (req_route)
   );

   assign accept = req_valid && !stall;

   nn_slot_seq #(.SLOTS(SLOTS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .in_route (req_route),
      .kind     (kind),
      .axis     (axis),
      .pos      (pos),
      .slot     (slot),
      .last     (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr[MEM_AW-1:0];
         we_q    <= req_we;
         wdata_q <= req_wdata;
      end
   end

   assign is_loc = (kind == ACC_LOCAL);
   assign is_rem = (kind == ACC_REMOTE);

   nn_lane_mux #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (is_rem),
      .slot   (slot),
      .wdata  (wdata_q),
      .rx     (link_rx),
      .tx     (tx_chunk),
      .word   (rx_word)
   );

   assign mem_en    = is_loc;
   assign mem_we    = is_loc && we_q;
   assign mem_addr  = (is_loc || is_rem) ? addr_q : '0;
   assign mem_wdata = (is_loc && we_q) ? wdata_q : '0;

   assign link_en   = is_rem;
   assign link_axis = axis;
   assign link_pos  = pos;
   assign link_slot = slot;
   assign link_we   = is_rem && we_q;
   assign link_tx   = (is_rem && we_q) ? tx_chunk : '0;

   assign stall = is_rem;
   assign done  = is_loc || (is_rem && last);
   assign err   = (kind == ACC_BAD);

   always_comb begin
      rd_data = '0;
      if (done && !we_q)
         rd_data = is_loc ? mem_rdata : rx_word;
   end

endmodule

// File: rtl/nn_access_seq_chk.sv
module nn_access_seq_chk #(
   parameter  int ADDR_W = 16,
   parameter  int SLOTS  = 4,
   localparam int MEM_AW = ADDR_W - 3,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              mem_en,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              link_en,
   input logic [1:0]        link_axis,
   input logic              link_pos,
   input logic [SLOT_W-1:0] link_slot,
   input logic              stall,
   input logic              done,
   input logic              err
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   logic [2:0] code;
   assign code = req_addr[ADDR_W-1 -: 3];

   a_r1_local_issue: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !stall && code == 3'd0 |=> mem_en && mem_addr == $past(req_addr[MEM_AW-1:0]));

   a_r2_local_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> done && !stall);

   a_r3_axis_known: assert property (@(posedge clk) disable iff (!rst_n)
      link_en |-> link_axis != 2'd0);

   a_r4_remote_start: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !stall && code != 3'd0 && code != 3'd7 |=> stall && link_en && link_slot == '0);

   a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      link_en && link_slot != LAST |=> link_en && stall && link_slot == $past(link_slot) + 1'b1);

   a_r4_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
      link_en && link_slot != LAST |=> $stable(link_axis) && $stable(link_pos) && $stable(mem_addr));

   a_r5_done_last: assert property (@(posedge clk) disable iff (!rst_n)
      link_en && done |-> link_slot == LAST);

   a_r5_stall_drop: assert property (@(posedge clk) disable iff (!rst_n)
      link_en && done |=> !stall);

   a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !stall && code == 3'd7 |=> err && !stall && !mem_en);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_en && link_en) && !(err && done));

endmodule

bind nn_access_seq nn_access_seq_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .mem_en    (mem_en),
   .mem_addr  (mem_addr),
   .link_en   (link_en),
   .link_axis (link_axis),
   .link_pos  (link_pos),
   .link_slot (link_slot),
   .stall     (stall),
   .done      (done),
   .err       (err)
);

// File: tb/tb_nn_access_seq.sv
module tb_nn_access_seq;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int SLOTS  = 4;
   localparam int MEM_AW = ADDR_W - 3;
   localparam int CW     = DATA_W / SLOTS;
   localparam int SW     = $clog2(SLOTS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_we = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic mem_en, mem_we, link_en, link_pos, link_we, stall, done, err;
   logic [MEM_AW-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata, rd_data;
   logic [1:0] link_axis;
   logic [SW-1:0] link_slot;
   logic [CW-1:0] link_tx, link_rx;

   always #10 clk = ~clk;

   function automatic logic [DATA_W-1:0] mem_fun(input logic [MEM_AW-1:0] a);
      return (32'(a) * 32'h0100_0193) ^ 32'hC3C3_0000;
   endfunction

   function automatic logic [DATA_W-1:0] rx_fun(input logic [MEM_AW-1:0] a, input logic [1:0] ax);
      return (32'(a) * 32'h9E37_79B1) ^ {ax, 30'd0};
   endfunction

   logic [DATA_W-1:0] rx_now;
   assign mem_rdata = mem_fun(mem_addr);
   assign rx_now    = rx_fun(mem_addr, link_axis);
   assign link_rx   = CW'(rx_now >> (32'(link_slot) * CW));

   nn_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .link_en(link_en), .link_axis(link_axis), .link_pos(link_pos),
      .link_slot(link_slot), .link_we(link_we), .link_tx(link_tx), .link_rx(link_rx),
      .stall(stall), .done(done), .rd_data(rd_data), .err(err)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // Behavioural reference: 0 idle, 1 local, 2 remote, 3 reserved
   int m_kind = 0;
   int m_slot = 0;
   int m_dir = 0;
   logic [MEM_AW-1:0] m_addr = '0;
   bit m_we = 0;
   logic [DATA_W-1:0] m_wd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_kind = 0; m_slot = 0;
      end else if (req_valid && m_kind != 2) begin
         int f;
         f = int'(req_addr[ADDR_W-1 -: 3]);
         m_addr = req_addr[MEM_AW-1:0];
         m_we = req_we;
         m_wd = req_wdata;
         m_dir = f;
         m_slot = 0;
         m_kind = (f == 0) ? 1 : (f == 7) ? 3 : 2;
      end else if (m_kind == 2 && m_slot < SLOTS - 1) begin
         m_slot++;
      end else begin
         m_kind = 0; m_slot = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit loc, rem, e_done;
         logic [DATA_W-1:0] e_rd;
         logic [CW-1:0] e_tx;
         loc = (m_kind == 1);
         rem = (m_kind == 2);
         e_done = loc || (rem && m_slot == SLOTS - 1);
         e_rd = '0;
         if (e_done && !m_we) e_rd = loc ? mem_fun(m_addr) : rx_fun(m_addr, 2'((m_dir + 1) / 2));
         e_tx = (rem && m_we) ? CW'(m_wd >> (m_slot * CW)) : '0;
         chk(mem_en == loc, "R1 mem_en", 64'(mem_en), 64'(loc));
         chk(mem_we == (loc && m_we), "R1 mem_we", 64'(mem_we), 64'(loc && m_we));
         chk(mem_addr == ((loc || rem) ? m_addr : '0), "R1 mem_addr", 64'(mem_addr), 64'(m_addr));
         chk(mem_wdata == ((loc && m_we) ? m_wd : '0), "R1 mem_wdata", 64'(mem_wdata), 64'(m_wd));
         chk(done == e_done, "R2/R5 done", 64'(done), 64'(e_done));
         chk(rd_data == e_rd, "R2/R7 rd_data", 64'(rd_data), 64'(e_rd));
         chk(link_axis == (rem ? 2'((m_dir + 1) / 2) : 2'd0), "R3 link_axis", 64'(link_axis), 64'((m_dir + 1) / 2));
         chk(link_pos == (rem && m_dir % 2 == 0), "R3 link_pos", 64'(link_pos), 64'(rem && m_dir % 2 == 0));
         chk(link_en == rem && stall == rem, "R4 link_en/stall", 64'({link_en, stall}), 64'({rem, rem}));
         chk(link_slot == (rem ? SW'(m_slot) : '0), "R4 link_slot", 64'(link_slot), 64'(m_slot));
         chk(link_we == (rem && m_we), "R6 link_we", 64'(link_we), 64'(rem && m_we));
         chk(link_tx == e_tx, "R6 link_tx", 64'(link_tx), 64'(e_tx));
         chk(err == (m_kind == 3), "R9 err", 64'(err), 64'(m_kind == 3));
         chk(!(mem_en && link_en) && !(err && done), "R11 exclusive", 64'({mem_en, link_en, err, done}), 64'd0);
      end
   end

   task automatic put(input bit v, input logic [2:0] f, input logic [MEM_AW-1:0] a,
                      input bit w, input logic [DATA_W-1:0] d);
      req_valid = v; req_addr = {f, a}; req_we = w; req_wdata = d;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      // R10: outputs quiet in reset
      chk({mem_en, link_en, stall, done, err, link_we, mem_we} == '0, "R10 reset outputs",
          64'({mem_en, link_en, stall, done, err, link_we, mem_we}), 64'd0);
      chk(rd_data == '0 && link_tx == '0 && link_axis == '0, "R10 reset data", 64'(rd_data), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: back-to-back local write then read
      put(1, 3'd0, 13'd5, 1, 32'hDEAD_BEEF);
      chk(mem_en && mem_we && mem_wdata == 32'hDEAD_BEEF, "R12 first local", 64'({mem_en, mem_we}), 64'd3);
      put(1, 3'd0, 13'd6, 0, 32'h0);
      chk(mem_en && !mem_we && rd_data == mem_fun(13'd6), "R12 second local", 64'(rd_data), 64'(mem_fun(13'd6)));
      put(0, 3'd0, 13'd0, 0, 32'h0);

      // R3/R4: every direction, read and write
      for (int dir = 1; dir <= 6; dir++) begin
         for (int w = 0; w < 2; w++) begin
            put(1, 3'(dir), 13'(dir * 100 + w), w[0], 32'h1234_5600 + 32'(dir));
            req_valid = 0;
            cnt = 0;
            while (stall) begin cnt++; @(negedge clk); end
            chk(cnt == SLOTS, "R4 stall length", 64'(cnt), 64'(SLOTS));
         end
      end

      // R8: reserved requests held during a remote access are ignored
      put(1, 3'd2, 13'd77, 0, 32'h0);
      for (int k = 0; k < SLOTS; k++) begin
         put(1, 3'd7, 13'd1, 0, 32'h0);
         chk(err == 0, "R8 ignored during stall", 64'(err), 64'd0);
      end
      chk(stall == 0, "R8 stall released", 64'(stall), 64'd0);
      put(0, 3'd0, 13'd0, 0, 32'h0);
      chk(err == 0 && !mem_en && !link_en, "R8 no late effect", 64'({err, mem_en, link_en}), 64'd0);

      // R9: reserved route code
      put(1, 3'd7, 13'd9, 1, 32'hFFFF_FFFF);
      chk(err && !stall && !mem_en && !done, "R9 reserved", 64'({err, stall, mem_en, done}), 64'h8);
      put(0, 3'd0, 13'd0, 0, 32'h0);

      // Random traffic, requests keep arriving during stalls
      for (int i = 0; i < 4000; i++) begin
         int f;
         f = $urandom_range(0, 9);
         if (f > 7) f = 0;
         put($urandom_range(0, 9) < 7, 3'(f), 13'($urandom), $urandom_range(0, 1) == 1, $urandom);
      end
      put(0, 3'd0, 13'd0, 0, 32'h0);
      repeat (SLOTS + 1) @(negedge clk);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule